// File: doc/BRIEF.md
# Shared-Bus 16-bit Processor Datapath

This block is the data half of a small load/store processor. Every transfer between its storage elements travels over a single 16-bit bus that exactly one source drives at a time. The sources are the program counter, the ALU result, the memory data register and the address-adder sum. Any of the registers may capture the bus value in the same cycle. The program counter and the memory address register also have private input muxes. An eight-entry register file feeds the ALU and the address adder. A three-bit condition-code register records the sign of whatever value is on the bus when it is told to.

The block makes no sequencing decisions. An external controller drives the individual gate enables, load enables, mux selects, register indices and the ALU operation code every cycle. The block carries out the resulting register transfer on the next rising clock edge. Memory sits outside the block. The block presents the memory address register and the memory data register as address and write data. It takes the read word back as an input.

Top module: `sbus_datapath`

## Requirements
- R1: The bus equals the value of the single source whose gate enable is high: `drv_pc` gates the PC, `drv_alu` gates the ALU result, `drv_mdata` gates the memory data register, and `drv_addr` gates the address-adder sum. With no enable high the bus reads zero. Two or more enables high in one cycle is illegal.
- R2: The PC, IR, memory address register, memory data register, register-file entries and condition code change only on a rising clock edge where their own load or write enable is 1. Otherwise they keep their value.
- R3: On `pc_load`, `pc_src` selects the next PC value. 00 selects PC+1, 01 selects the address-adder sum, 10 selects the bus value, and 11 behaves like 00.
- R4: The address-adder sum is a base plus an offset, both 16 bits. `adder_base`=0 picks the PC as base and 1 picks read port A. `adder_off` picks the offset: 00 is zero, 01 is IR[5:0] sign-extended, 10 is IR[8:0] sign-extended, and 11 is IR[10:0] sign-extended.
- R5: On `maddr_load`, the memory address register takes the address-adder sum when `maddr_src`=0. When `maddr_src`=1 it takes IR[7:0] zero-extended to 16 bits.
- R6: The register file has two combinational read ports, indexed by `rd_a_idx` and `rd_b_idx`. On `rf_write` the entry at `wr_idx` is written with the bus value.
- R7: The ALU takes operand A from read port A. Operand B comes from read port B, or from IR[4:0] sign-extended when `alu_b_imm`=1. `alu_op` selects the result: 00 is A+B (mod 2^16), 01 is A AND B, 10 is NOT A, and 11 is A.
- R8: On `mdata_load`, the memory data register takes `mem_rdata` when `mem_en`=1 and `mem_we`=0, and takes the bus value otherwise. `mem_addr` always shows the memory address register and `mem_wdata` always shows the memory data register. A memory write enabled with `mem_we`=1 therefore stores the memory data register at the address in the memory address register.
- R9: On `flags_load`, the condition code `flags_o` (bit 2 = negative, bit 1 = zero, bit 0 = positive) becomes 100 if bus bit 15 is set, 010 if the bus is zero, and 001 otherwise. Exactly one bit is always set.
- R10: While `rst_n` is low at a rising edge, the PC, IR, memory address register, memory data register and all eight register-file entries become zero, and `flags_o` becomes 010.
- R11: On `instr_load`, the IR takes the bus value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| drv_pc | input | 1 | Gate the PC onto the bus |
| drv_alu | input | 1 | Gate the ALU result onto the bus |
| drv_mdata | input | 1 | Gate the memory data register onto the bus |
| drv_addr | input | 1 | Gate the address-adder sum onto the bus |
| pc_load | input | 1 | PC load enable |
| pc_src | input | 2 | PC source select |
| maddr_load | input | 1 | Memory address register load enable |
| maddr_src | input | 1 | Memory address register source select |
| mdata_load | input | 1 | Memory data register load enable |
| mem_en | input | 1 | Memory access enable for this cycle |
| mem_we | input | 1 | Memory access is a write |
| instr_load | input | 1 | IR load enable |
| rf_write | input | 1 | Register-file write enable |
| wr_idx | input | 3 | Register-file write index |
| rd_a_idx | input | 3 | Read port A index |
| rd_b_idx | input | 3 | Read port B index |
| alu_op | input | 2 | ALU operation code |
| alu_b_imm | input | 1 | ALU operand B from IR immediate |
| adder_base | input | 1 | Address-adder base select |
| adder_off | input | 2 | Address-adder offset select |
| flags_load | input | 1 | Condition-code load enable |
| mem_rdata | input | 16 | Word read from memory at `mem_addr` |
| bus_o | output | 16 | Current bus value |
| pc_o | output | 16 | Program counter |
| ir_o | output | 16 | Instruction register |
| mem_addr | output | 16 | Memory address register |
| mem_wdata | output | 16 | Memory data register |
| flags_o | output | 3 | Condition code {N, Z, P} |

## Verification
The embedded assertions check the following on every cycle:
- at most one gate enable is high;
- the condition code stays one-hot and changes only when loaded;
- the PC holds unless loaded and steps by one on the increment path;
- a register-file write lands in the addressed entry;
- the memory data register captures the read word on a memory read;
- the zero-extended IR byte reaches the address register.

Only the bench scenarios can show the following:
- the value of each sign-extended offset and immediate;
- the ALU result for each operation;
- that the idle bus reads zero and sets the zero flag;
- that a word written through the memory port reads back unchanged.

A bench model of all storage, run under long constrained-random control sequences, shows that no combination of loads disturbs a register it does not name.

// File: rtl/sbus_pkg.sv
// Package: shared types and constants for the shared-bus datapath.
// Assumes a 16-bit machine word; field positions in the IR are fixed.
package sbus_pkg;

    // ALU operation codes, 2 bits wide.
    typedef enum logic [1:0] {
        ALU_ADD  = 2'b00,
        ALU_AND  = 2'b01,
        ALU_NOT  = 2'b10,
        ALU_PASS = 2'b11
    } alu_op_e;

    // PC source select codes.
    localparam logic [1:0] PC_SRC_INC   = 2'b00;
    localparam logic [1:0] PC_SRC_ADDER = 2'b01;
    localparam logic [1:0] PC_SRC_BUS   = 2'b10;

    // Address-adder offset select codes.
    localparam logic [1:0] OFF_ZERO = 2'b00;
    localparam logic [1:0] OFF_S6   = 2'b01;
    localparam logic [1:0] OFF_S9   = 2'b10;
    localparam logic [1:0] OFF_S11  = 2'b11;

    // Bus source slots in the one-hot select vector.
    localparam int BUS_SRC_PC    = 0;
    localparam int BUS_SRC_ALU   = 1;
    localparam int BUS_SRC_MDATA = 2;
    localparam int BUS_SRC_ADDR  = 3;
    localparam int BUS_SRC_COUNT = 4;

    // Condition-code bit positions: {negative, zero, positive}.
    localparam int FLAG_N = 2;
    localparam int FLAG_Z = 1;
    localparam int FLAG_P = 0;

endpackage

// File: rtl/sbus_bus_mux.sv
// Module: one-hot selected bus driver.
// Models the gated bus drivers as an AND-OR mux. It assumes the controller
// raises at most one select per cycle; an all-zero select yields zero.
module sbus_bus_mux #(
    parameter int WIDTH   = 16,
    parameter int SOURCES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SOURCES-1:0]             sel,
    input  logic [SOURCES-1:0][WIDTH-1:0]  src,
    output logic [WIDTH-1:0]               bus
);

    // Purpose: OR together every source masked by its select bit.
    always_comb begin
        bus = '0;
        for (int i = 0; i < SOURCES; i++) begin
            bus = bus | (src[i] & {WIDTH{sel[i]}});
        end
    end

    // R1: no two drivers may share the bus in one cycle.
    assert_single_driver_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) <= 1);

endmodule

// File: rtl/sbus_regfile.sv
// Module: general register file with two read ports and one write port.
// Reads are combinational. The write takes effect at the rising edge when
// the write enable is high. Synchronous active-low reset clears all entries.
module sbus_regfile #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WIDTH-1:0]  wdata,
    input  logic [IDX_W-1:0]  raddr_a,
    input  logic [IDX_W-1:0]  raddr_b,
    output logic [WIDTH-1:0]  rdata_a,
    output logic [WIDTH-1:0]  rdata_b
);

    logic [WIDTH-1:0] regs [DEPTH];
    logic [DEPTH-1:0] wsel;

    // Purpose: per-entry write strobe from the write index.
    for (genvar g = 0; g < DEPTH; g++) begin : g_wdec
        assign wsel[g] = we && (waddr == IDX_W'(g));
    end

    // Purpose: clear on reset, otherwise update the strobed entry.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                regs[i] <= '0;
            end else if (wsel[i]) begin
                regs[i] <= wdata;
            end
        end
    end

    // Purpose: combinational read ports.
    always_comb begin
        rdata_a = regs[raddr_a];
        rdata_b = regs[raddr_b];
    end

    // R6: a written value is present in the addressed entry one edge later.
    assert_write_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (regs[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/sbus_alu.sv
// Module: small ALU with add, and, not and pass operations.
// Purely combinational; the addition wraps modulo 2^WIDTH.
module sbus_alu
    import sbus_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [1:0]        op,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    output logic [WIDTH-1:0]  y
);

    alu_op_e op_e;
    assign op_e = alu_op_e'(op);

    // Purpose: pick the result for the requested operation.
    always_comb begin
        unique case (op_e)
            ALU_ADD:  y = a + b;
            ALU_AND:  y = a & b;
            ALU_NOT:  y = ~a;
            ALU_PASS: y = a;
            default:  y = a;
        endcase
    end

endmodule

// File: rtl/sbus_flags.sv
// Module: condition-code register.
// Classifies the bus value as negative, zero or positive and stores the
// one-hot result when loaded. Reset leaves the zero flag set.
module sbus_flags
    import sbus_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WIDTH-1:0]  bus,
    output logic [2:0]        flags
);

    logic [2:0] flags_next;

    // Purpose: classify the bus value into a one-hot sign code.
    always_comb begin
        flags_next = '0;
        if (bus[WIDTH-1]) begin
            flags_next[FLAG_N] = 1'b1;
        end else if (bus == '0) begin
            flags_next[FLAG_Z] = 1'b1;
        end else begin
            flags_next[FLAG_P] = 1'b1;
        end
    end

    // Purpose: hold the code, update it on load, force zero flag on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= 3'b010;
        end else if (load) begin
            flags <= flags_next;
        end
    end

    // R9: exactly one condition bit is set at all times after reset.
    assert_flags_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1);

    // R2: the condition code holds when not loaded.
    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flags));

endmodule

// File: rtl/sbus_datapath.sv
// Module: shared-bus 16-bit processor datapath (top).
// Holds PC, IR, memory address and data registers. It connects them, the
// register file, the ALU, the address adder and the condition code through
// one gated bus. All control comes from an external controller that drives
// each enable and select directly. It assumes at most one gate enable per
// cycle, and a memory outside the block that returns mem_rdata for
// mem_addr in the same cycle. Synchronous active-low reset.
module sbus_datapath
    import sbus_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int REG_NUM  = 8,
    localparam int IDX_W   = $clog2(REG_NUM),
    localparam int IMM_W   = 5,
    localparam int OFF6_W  = 6,
    localparam int OFF9_W  = 9,
    localparam int OFF11_W = 11,
    localparam int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               drv_pc,
    input  logic               drv_alu,
    input  logic               drv_mdata,
    input  logic               drv_addr,
    input  logic               pc_load,
    input  logic [1:0]         pc_src,
    input  logic               maddr_load,
    input  logic               maddr_src,
    input  logic               mdata_load,
    input  logic               mem_en,
    input  logic               mem_we,
    input  logic               instr_load,
    input  logic               rf_write,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [IDX_W-1:0]   rd_a_idx,
    input  logic [IDX_W-1:0]   rd_b_idx,
    input  logic [1:0]         alu_op,
    input  logic               alu_b_imm,
    input  logic               adder_base,
    input  logic [1:0]         adder_off,
    input  logic               flags_load,
    input  logic [DATA_W-1:0]  mem_rdata,
    output logic [DATA_W-1:0]  bus_o,
    output logic [DATA_W-1:0]  pc_o,
    output logic [DATA_W-1:0]  ir_o,
    output logic [DATA_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    output logic [2:0]         flags_o
);

    logic [DATA_W-1:0] pc_q, ir_q, mar_q, mdr_q;
    logic [DATA_W-1:0] bus;
    logic [DATA_W-1:0] port_a, port_b;
    logic [DATA_W-1:0] alu_b, alu_y;
    logic [DATA_W-1:0] add_base, add_off, add_sum;
    logic [DATA_W-1:0] pc_next, mar_next, mdr_next;
    logic [BUS_SRC_COUNT-1:0]             bus_sel;
    logic [BUS_SRC_COUNT-1:0][DATA_W-1:0] bus_src;

    // Purpose: gather the gate enables and sources for the bus mux.
    always_comb begin
        bus_sel                = '0;
        bus_sel[BUS_SRC_PC]    = drv_pc;
        bus_sel[BUS_SRC_ALU]   = drv_alu;
        bus_sel[BUS_SRC_MDATA] = drv_mdata;
        bus_sel[BUS_SRC_ADDR]  = drv_addr;
        bus_src                = '0;
        bus_src[BUS_SRC_PC]    = pc_q;
        bus_src[BUS_SRC_ALU]   = alu_y;
        bus_src[BUS_SRC_MDATA] = mdr_q;
        bus_src[BUS_SRC_ADDR]  = add_sum;
    end

    sbus_bus_mux #(
        .WIDTH   (DATA_W),
        .SOURCES (BUS_SRC_COUNT)
    ) u_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (bus_sel),
        .src   (bus_src),
        .bus   (bus)
    );

    sbus_regfile #(
        .WIDTH (DATA_W),
        .DEPTH (REG_NUM)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_write),
        .waddr   (wr_idx),
        .wdata   (bus),
        .raddr_a (rd_a_idx),
        .raddr_b (rd_b_idx),
        .rdata_a (port_a),
        .rdata_b (port_b)
    );

    // Purpose: ALU operand B from port B or the sign-extended IR immediate.
    always_comb begin
        if (alu_b_imm) begin
            alu_b = {{(DATA_W-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        end else begin
            alu_b = port_b;
        end
    end

    sbus_alu #(
        .WIDTH (DATA_W)
    ) u_alu (
        .op (alu_op),
        .a  (port_a),
        .b  (alu_b),
        .y  (alu_y)
    );

    // Purpose: address adder base and sign-extended offset selection.
    always_comb begin
        add_base = adder_base ? port_a : pc_q;
        unique case (adder_off)
            OFF_ZERO: add_off = '0;
            OFF_S6:   add_off = {{(DATA_W-OFF6_W){ir_q[OFF6_W-1]}},   ir_q[OFF6_W-1:0]};
            OFF_S9:   add_off = {{(DATA_W-OFF9_W){ir_q[OFF9_W-1]}},   ir_q[OFF9_W-1:0]};
            OFF_S11:  add_off = {{(DATA_W-OFF11_W){ir_q[OFF11_W-1]}}, ir_q[OFF11_W-1:0]};
            default:  add_off = '0;
        endcase
        add_sum = add_base + add_off;
    end

    // Purpose: PC input mux; the unused code falls back to increment.
    always_comb begin
        unique case (pc_src)
            PC_SRC_ADDER: pc_next = add_sum;
            PC_SRC_BUS:   pc_next = bus;
            default:      pc_next = pc_q + 1'b1;
        endcase
    end

    // Purpose: memory address register input mux.
    always_comb begin
        if (maddr_src) begin
            mar_next = {{(DATA_W-BYTE_W){1'b0}}, ir_q[BYTE_W-1:0]};
        end else begin
            mar_next = add_sum;
        end
    end

    // Purpose: memory data register input, memory word on a read else bus.
    always_comb begin
        if (mem_en && !mem_we) begin
            mdr_next = mem_rdata;
        end else begin
            mdr_next = bus;
        end
    end

    // Purpose: program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (pc_load) begin
            pc_q <= pc_next;
        end
    end

    // Purpose: instruction register, loaded from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (instr_load) begin
            ir_q <= bus;
        end
    end

    // Purpose: memory address register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (maddr_load) begin
            mar_q <= mar_next;
        end
    end

    // Purpose: memory data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdr_q <= '0;
        end else if (mdata_load) begin
            mdr_q <= mdr_next;
        end
    end

    sbus_flags #(
        .WIDTH (DATA_W)
    ) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (flags_load),
        .bus   (bus),
        .flags (flags_o)
    );

    // Purpose: drive the observation and memory-port outputs.
    always_comb begin
        bus_o     = bus;
        pc_o      = pc_q;
        ir_o      = ir_q;
        mem_addr  = mar_q;
        mem_wdata = mdr_q;
    end

    // R2: the PC holds when its load is low.
    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_load |=> $stable(pc_q));

    // R3: the increment path advances the PC by exactly one.
    assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_load && pc_src == PC_SRC_INC) |=> (pc_q == $past(pc_q) + 1'b1));

    // R8: a memory read captures the word presented on the read port.
    assert_mdata_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mdata_load && mem_en && !mem_we) |=> (mdr_q == $past(mem_rdata)));

    // R5: the byte path loads IR[7:0] with zeros above it.
    assert_maddr_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (maddr_load && maddr_src) |=>
            (mar_q == {{(DATA_W-BYTE_W){1'b0}}, $past(ir_q[BYTE_W-1:0])}));

endmodule

// File: tb/sbus_datapath_tb.sv
`timescale 1ns/1ps
module sbus_datapath_tb;

    localparam int CLK_HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        drv_pc, drv_alu, drv_mdata, drv_addr;
    logic        pc_load, maddr_load, maddr_src, mdata_load;
    logic        mem_en, mem_we, instr_load, rf_write;
    logic [1:0]  pc_src, alu_op, adder_off;
    logic [2:0]  wr_idx, rd_a_idx, rd_b_idx;
    logic        alu_b_imm, adder_base, flags_load;
    logic [15:0] mem_rdata;
    logic [15:0] bus_o, pc_o, ir_o, mem_addr, mem_wdata;
    logic [2:0]  flags_o;

    // Bench memory and reference model of every storage element.
    logic [15:0] bmem [256];
    logic [15:0] m_pc, m_ir, m_mar, m_mdr;
    logic [15:0] m_rf [8];
    logic [2:0]  m_fl;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 0;

    always #CLK_HALF clk = ~clk;

    assign mem_rdata = bmem[mem_addr[7:0]];

    sbus_datapath u_dut (
        .clk(clk), .rst_n(rst_n),
        .drv_pc(drv_pc), .drv_alu(drv_alu), .drv_mdata(drv_mdata), .drv_addr(drv_addr),
        .pc_load(pc_load), .pc_src(pc_src),
        .maddr_load(maddr_load), .maddr_src(maddr_src),
        .mdata_load(mdata_load), .mem_en(mem_en), .mem_we(mem_we),
        .instr_load(instr_load), .rf_write(rf_write),
        .wr_idx(wr_idx), .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .alu_op(alu_op), .alu_b_imm(alu_b_imm),
        .adder_base(adder_base), .adder_off(adder_off),
        .flags_load(flags_load), .mem_rdata(mem_rdata),
        .bus_o(bus_o), .pc_o(pc_o), .ir_o(ir_o),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .flags_o(flags_o)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [15:0] v, input int n);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = (i < n) ? v[i] : v[n-1];
        return r;
    endfunction

    function automatic logic [15:0] ref_adder();
        logic [15:0] base, off;
        base = adder_base ? m_rf[rd_a_idx] : m_pc;
        case (adder_off)
            2'b00:   off = 16'h0000;
            2'b01:   off = sx(m_ir, 6);
            2'b10:   off = sx(m_ir, 9);
            default: off = sx(m_ir, 11);
        endcase
        return base + off;
    endfunction

    function automatic logic [15:0] ref_alu();
        logic [15:0] a, b;
        a = m_rf[rd_a_idx];
        b = alu_b_imm ? sx(m_ir, 5) : m_rf[rd_b_idx];
        case (alu_op)
            2'b00:   return a + b;
            2'b01:   return a & b;
            2'b10:   return ~a;
            default: return a;
        endcase
    endfunction

    function automatic logic [15:0] ref_bus();
        if (drv_pc)    return m_pc;
        if (drv_alu)   return ref_alu();
        if (drv_mdata) return m_mdr;
        if (drv_addr)  return ref_adder();
        return 16'h0000;
    endfunction

    function automatic logic [2:0] ref_flags(input logic [15:0] v);
        if (v[15])        return 3'b100;
        if (v == 16'h0)   return 3'b010;
        return 3'b001;
    endfunction

    task automatic idle();
        {drv_pc, drv_alu, drv_mdata, drv_addr} = '0;
        {pc_load, maddr_load, maddr_src, mdata_load, mem_en, mem_we} = '0;
        {instr_load, rf_write, alu_b_imm, adder_base, flags_load} = '0;
        pc_src = '0; alu_op = '0; adder_off = '0;
        wr_idx = '0; rd_a_idx = '0; rd_b_idx = '0;
    endtask

    // Called just after a falling edge with inputs set: checks the bus,
    // advances the model at the rising edge, checks state at the next fall.
    task automatic cycle(input string bus_tag);
        logic [15:0] eb, n_pc, n_mar, n_mdr;
        #2;
        eb = ref_bus();
        chk(bus_tag, bus_o, eb);
        n_pc = m_pc;
        if (pc_load) begin
            case (pc_src)
                2'b01:   n_pc = ref_adder();
                2'b10:   n_pc = eb;
                default: n_pc = m_pc + 16'd1;
            endcase
        end
        n_mar = m_mar;
        if (maddr_load) n_mar = maddr_src ? {8'h00, m_ir[7:0]} : ref_adder();
        n_mdr = m_mdr;
        if (mdata_load) n_mdr = (mem_en && !mem_we) ? bmem[m_mar[7:0]] : eb;
        @(posedge clk);
        #1;
        if (mem_en && mem_we) bmem[m_mar[7:0]] = m_mdr;
        if (rf_write)   m_rf[wr_idx] = eb;
        if (instr_load) m_ir = eb;
        if (flags_load) m_fl = ref_flags(eb);
        m_pc = n_pc; m_mar = n_mar; m_mdr = n_mdr;
        @(negedge clk);
        chk(pc_load    ? "R3 pc"  : "R2 pc",  pc_o, m_pc);
        chk(instr_load ? "R11 ir" : "R2 ir",  ir_o, m_ir);
        chk(maddr_load ? "R5 mar" : "R2 mar", mem_addr, m_mar);
        chk(mdata_load ? "R8 mdr" : "R2 mdr", mem_wdata, m_mdr);
        chk(flags_load ? "R9 flags" : "R2 flags", {13'h0, flags_o}, {13'h0, m_fl});
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_HALF * 2 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        for (int i = 0; i < 256; i++) bmem[i] = 16'($urandom);
        bmem[0] = 16'h8001; bmem[1] = 16'h0000; bmem[2] = 16'h7FFF; bmem[3] = 16'hFFFF;
        bmem[4] = 16'h0A93; bmem[5] = 16'h0534;
        idle();
        rst_n = 1'b0;
        m_pc = '0; m_ir = '0; m_mar = '0; m_mdr = '0; m_fl = 3'b010;
        for (int i = 0; i < 8; i++) m_rf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: reset state of every register and the condition code.
        chk("R10 pc", pc_o, 16'h0);
        chk("R10 ir", ir_o, 16'h0);
        chk("R10 mar", mem_addr, 16'h0);
        chk("R10 mdr", mem_wdata, 16'h0);
        chk("R10 flags", {13'h0, flags_o}, 16'h0002);
        for (int k = 0; k < 8; k++) begin
            idle(); drv_alu = 1; alu_op = 2'b11; rd_a_idx = 3'(k);
            cycle("R10 regfile");
        end

        // R1: idle bus reads zero and loads the zero flag.
        idle(); flags_load = 1; cycle("R1 idle bus");

        // R6/R8: fill the register file from memory words 0..7.
        for (int k = 0; k < 8; k++) begin
            idle(); drv_pc = 1; maddr_load = 1; pc_load = 1;   // address <- pc, pc+1
            cycle("R1 pc on bus");
            idle(); mem_en = 1; mdata_load = 1;                 // read word
            cycle("R8 read");
            idle(); drv_mdata = 1; rf_write = 1; wr_idx = 3'(k); flags_load = 1;
            cycle("R6 write");
        end
        // R9: reg0=8001 negative, reg1=0 zero, reg2=7FFF positive.
        for (int k = 0; k < 3; k++) begin
            idle(); drv_alu = 1; alu_op = 2'b11; rd_a_idx = 3'(k); flags_load = 1;
            cycle("R9 sign source");
        end
        // R6: read both ports of every entry.
        for (int k = 0; k < 8; k++) begin
            idle(); drv_alu = 1; alu_op = 2'b11; rd_a_idx = 3'(k);
            cycle("R6 port A");
            idle(); drv_alu = 1; alu_op = 2'b00; rd_a_idx = 3'd1; rd_b_idx = 3'(k);
            cycle("R6 port B");
        end
        // R11: IR from reg4 (0A93).
        idle(); drv_alu = 1; alu_op = 2'b11; rd_a_idx = 3'd4; instr_load = 1;
        cycle("R11 ir load");
        // R7: every operation, register and immediate operand B.
        for (int op = 0; op < 4; op++) begin
            for (int im = 0; im < 2; im++) begin
                idle(); drv_alu = 1; alu_op = 2'(op); alu_b_imm = 1'(im);
                rd_a_idx = 3'd3; rd_b_idx = 3'd2;
                cycle("R7 alu");
                idle(); drv_alu = 1; alu_op = 2'(op); alu_b_imm = 1'(im);
                rd_a_idx = 3'd0; rd_b_idx = 3'd6;
                cycle("R7 alu");
            end
        end
        // R4: each offset and base, with IR=0A93 then IR=0534.
        for (int w = 0; w < 2; w++) begin
            for (int b = 0; b < 2; b++) begin
                for (int o = 0; o < 4; o++) begin
                    idle(); drv_addr = 1; adder_base = 1'(b); adder_off = 2'(o);
                    rd_a_idx = 3'd7;
                    cycle("R4 adder");
                end
            end
            idle(); drv_alu = 1; alu_op = 2'b11; rd_a_idx = 3'd5; instr_load = 1;
            cycle("R11 ir load");
        end
        // R5: both address sources.
        idle(); maddr_load = 1; maddr_src = 1; cycle("R5 byte");
        idle(); maddr_load = 1; adder_base = 1; adder_off = 2'b10; rd_a_idx = 3'd2;
        cycle("R5 adder");
        // R3: every PC source code.
        for (int s = 0; s < 4; s++) begin
            idle(); pc_load = 1; pc_src = 2'(s); drv_alu = 1; alu_op = 2'b11;
            rd_a_idx = 3'd3; adder_off = 2'b11;
            cycle("R3 pc source");
        end
        // R8: write through the memory port, then read it back.
        idle(); maddr_load = 1; maddr_src = 1; cycle("R8 addr");
        idle(); mdata_load = 1; drv_alu = 1; alu_op = 2'b10; rd_a_idx = 3'd2;
        cycle("R8 mdr from bus");
        idle(); mem_en = 1; mem_we = 1; cycle("R8 write");
        idle(); mdata_load = 1; drv_pc = 1; cycle("R8 clobber");
        idle(); mem_en = 1; mdata_load = 1; cycle("R8 readback");
        chk("R8 readback", mem_wdata, 16'h8000);
        // R2: a cycle with every load low changes nothing.
        idle(); drv_addr = 1; adder_off = 2'b01; cycle("R2 no loads");

        // Constrained random control sequences.
        for (int t = 0; t < 4000; t++) begin
            int d;
            idle();
            d = int'($urandom_range(0, 4));
            drv_pc = (d == 1); drv_alu = (d == 2); drv_mdata = (d == 3); drv_addr = (d == 4);
            pc_load    = ($urandom_range(0, 3) == 0);
            pc_src     = 2'($urandom);
            maddr_load = ($urandom_range(0, 2) == 0);
            maddr_src  = 1'($urandom);
            mdata_load = ($urandom_range(0, 2) == 0);
            mem_en     = 1'($urandom);
            mem_we     = 1'($urandom);
            instr_load = ($urandom_range(0, 3) == 0);
            rf_write   = 1'($urandom);
            wr_idx     = 3'($urandom); rd_a_idx = 3'($urandom); rd_b_idx = 3'($urandom);
            alu_op     = 2'($urandom); alu_b_imm = 1'($urandom);
            adder_base = 1'($urandom); adder_off = 2'($urandom);
            flags_load = 1'($urandom);
            cycle("R1 random bus");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule